// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a fixed oscillator clock into a steady one-microsecond tick. It also counts those ticks in a free-running counter. The step from oscillator to tick is a ratio of two small integers, (dividend+1)/(divisor+1). Because of this, an oscillator whose frequency is not a whole number of megahertz still gives an exact 1 MHz average. Two examples:

- At 19.2 MHz, software programs dividend 4 and divisor 95, which gives 5 ticks every 96 clocks.
- At 12, 13 or 26 MHz, software programs dividend 0 and a divisor of the frequency in MHz minus one.

The one-cycle tick pulse is exported so that interval timers elsewhere can count microseconds.

Software reaches the block through a small register port with two addresses: the configuration word and the counter. Reads come back registered one cycle after the request. The divider is a running-sum accumulator driven by a two-state machine:

- **FLUSH** holds the accumulator at zero and emits no tick.
- **RUN** adds (dividend+1) on every clock. When the sum reaches (divisor+1), it subtracts that modulus and raises the tick.

The transitions are:

- *reset → FLUSH*
- *config write → FLUSH*, taken from either state
- *FLUSH → RUN*, after one cycle
- *RUN → RUN*, on every cycle without a write

Top module: `ustb_timebase`

## Requirements
- R1: After reset, the counter and the configuration are 0 and `us_tick` is low. The tick first rises in the second cycle after reset is released, and it then stays high every cycle, because the default ratio is 1/1.
- R2: A write with `reg_we`=1 and `reg_addr`=1 loads the configuration: the dividend from `reg_wdata[15:8]` and the divisor from `reg_wdata[7:0]`. A read at address 1 returns the same word in bits [15:0], with zeros above.
- R3: Let N = dividend+1 and D = divisor+1, with N < D. Number the RUN cycles from n = 1. RUN cycle n produces a tick exactly when floor(n·N/D) > floor((n-1)·N/D), and the tick is visible on `us_tick` for one cycle, in the cycle after RUN cycle n. The long-run tick rate is therefore N/D of the clock.
- R4: When N ≥ D, every RUN cycle produces a tick, and the accumulator never exceeds the divisor.
- R5: A configuration write clears the accumulator and the tick. The cycle after the write edge is a FLUSH cycle, with no tick. RUN cycles are counted again from n = 1, starting in the following cycle, using the new ratio. A second write made directly after the first restarts the count once more.
- R6: The counter goes up by exactly one at the clock edge that ends each tick cycle, and holds at all other edges. It is 32 bits wide (the `CNT_W` parameter) and wraps from all ones to 0.
- R7: A read at address 0 returns, on `reg_rdata` in the next cycle, the whole counter value present in the cycle of the request. A read made in a tick cycle therefore returns the value before that tick's increment.
- R8: `reg_rdata` keeps its last value in every cycle in which `reg_re` is low.
- R9: A write with `reg_addr`=0 changes neither the configuration nor the tick sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 1 | Register select: 0 counter, 1 configuration |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data: dividend [15:8], divisor [7:0] |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| us_tick | output | 1 | One-cycle microsecond tick pulse |

## Verification
Two pairs of events can fall on the same clock edge.

- **Counter read and tick increment.** At ratio 1/1 every cycle is a tick cycle, so every read under that ratio coincides with an increment. The bench judges each returned value against a count it builds from its own predicted tick sequence. That value must leave out the tick of the request cycle.
- **Configuration write and a pending tick.** Writes are issued while ticks are due, and two writes are issued back to back. The scoreboard drops every tick it had predicted from the write edge onward. Any tick that then appears in the FLUSH cycle is reported.

// File: rtl/ustb_pkg.sv
package ustb_pkg;

    // Divider control states
    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } ustb_state_e;

    // Register port address map
    typedef enum logic {
        ADDR_COUNT = 1'b0,
        ADDR_CFG   = 1'b1
    } ustb_addr_e;

endpackage

// File: rtl/ustb_frac_div.sv
module ustb_frac_div
    import ustb_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart_i,
    input  logic [FIELD_W-1:0] dvd_i,
    input  logic [FIELD_W-1:0] dvs_i,
    output logic               tick_o
);

    localparam int SUM_W = FIELD_W + 2;

    ustb_state_e      state_q, nxt_state;
    logic [SUM_W-1:0] acc_q, nxt_acc;
    logic             nxt_tick;
    logic [SUM_W-1:0] step_w, modulus_w, sum_w, rem_w;

    assign step_w    = SUM_W'(dvd_i) + SUM_W'(1);
    assign modulus_w = SUM_W'(dvs_i) + SUM_W'(1);
    assign sum_w     = acc_q + step_w;
    assign rem_w     = sum_w - modulus_w;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FLUSH;
        else     state_q <= nxt_state;
    end

    // Next state, accumulator and tick decisions
    always_comb begin
        nxt_state = state_q;
        nxt_acc   = acc_q;
        nxt_tick  = 1'b0;
        if (restart_i) begin
            nxt_state = ST_FLUSH;
            nxt_acc   = '0;
        end else begin
            unique case (state_q)
                ST_FLUSH: begin
                    nxt_state = ST_RUN;
                    nxt_acc   = '0;
                end
                ST_RUN: begin
                    if (sum_w >= modulus_w) begin
                        nxt_tick = 1'b1;
                        nxt_acc  = (rem_w >= modulus_w) ? '0 : rem_w;
                    end else begin
                        nxt_acc  = sum_w;
                    end
                end
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= nxt_acc;
            tick_o <= nxt_tick;
        end
    end

    assert_flush_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH) |=> !tick_o);

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (acc_q == '0 && state_q == ST_FLUSH));

    assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        acc_q <= SUM_W'(dvs_i));

endmodule

// File: rtl/ustb_us_counter.sv
module ustb_us_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);

    always_ff @(posedge clk) begin
        if (rst)         count_o <= '0;
        else if (tick_i) count_o <= count_o + CNT_W'(1);
    end

    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (count_o == $past(count_o) + CNT_W'(1)));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));

endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase
    import ustb_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int CNT_W   = 32,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_addr,
    input  logic                 reg_we,
    input  logic [2*FIELD_W-1:0] reg_wdata,
    input  logic                 reg_re,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 us_tick
);

    localparam int CFG_W = 2 * FIELD_W;

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_wr;
    logic [CNT_W-1:0] count_w;

    assign cfg_wr = reg_we && (reg_addr == ADDR_CFG);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= reg_wdata;
    end

    ustb_frac_div #(.FIELD_W(FIELD_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .restart_i (cfg_wr),
        .dvd_i     (cfg_q[CFG_W-1:FIELD_W]),
        .dvs_i     (cfg_q[FIELD_W-1:0]),
        .tick_o    (us_tick)
    );

    ustb_us_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (us_tick),
        .count_o (count_w)
    );

    // Whole-word read capture in a single edge
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            if (reg_addr == ADDR_COUNT) reg_rdata <= DATA_W'(count_w);
            else                        reg_rdata <= DATA_W'(cfg_q);
        end
    end

    assert_read_coherent_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == ADDR_COUNT) |=> (reg_rdata == DATA_W'($past(count_w))));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata));

    assert_ignored_write_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_COUNT) |=> $stable(cfg_q));

endmodule

// File: tb/ustb_timebase_bench.sv
module ustb_timebase_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PLAN_LEN   = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_addr = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [31:0] rdata_main, rdata_narrow;
    logic        tick_main, tick_narrow;

    always #(CLK_PERIOD/2) clk = ~clk;

    ustb_timebase u_ustb_timebase (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata_main),
        .us_tick(tick_main)
    );

    // Narrow counter copy, used to reach the wrap point quickly
    ustb_timebase #(.CNT_W(8)) u_ustb_timebase_narrow (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(rdata_narrow),
        .us_tick(tick_narrow)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    edge_no = 0;
    int    exp_q[$];
    int    tick_total = 0;
    int    cnt_now = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic [15:0] cfg_exp = '0;

    always @(posedge clk) edge_no++;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the predicted tick edges and compares every cycle
    always @(negedge clk) begin
        if (mon_on && !done) begin
            bit exp_t;
            exp_t = (exp_q.size() > 0 && exp_q[0] == edge_no);
            if (exp_t) void'(exp_q.pop_front());
            check(cur_tag, "us_tick", longint'(tick_main), longint'(exp_t));
            check("R6", "narrow us_tick", longint'(tick_narrow), longint'(exp_t));
            if (exp_t) tick_total++;
            cnt_now = tick_total - int'(exp_t);
        end
    end

    // Driver side: predicted tick edges for a ratio started at edge w
    task automatic plan(input int w, input int dvd, input int dvs);
        int nn = dvd + 1;
        int dd = dvs + 1;
        while (exp_q.size() > 0 && exp_q[$] >= w) void'(exp_q.pop_back());
        for (int n = 1; n <= PLAN_LEN; n++) begin
            if (nn >= dd || (n * nn) / dd > ((n - 1) * nn) / dd)
                exp_q.push_back(w + 1 + n);
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic addr, input int dvd, input int dvs, input string tag);
        @(negedge clk); #1;
        cur_tag   = tag;
        reg_addr  = addr;
        reg_we    = 1'b1;
        reg_wdata = {8'(dvd), 8'(dvs)};
        if (addr) begin
            plan(edge_no + 1, dvd, dvs);
            cfg_exp = {8'(dvd), 8'(dvs)};
        end
        @(negedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic do_read(input logic addr, input string tag);
        longint e;
        @(negedge clk); #1;
        e = addr ? longint'(cfg_exp) : longint'(cnt_now);
        reg_addr = addr;
        reg_re   = 1'b1;
        @(negedge clk); #1;
        reg_re = 1'b0;
        check(tag, addr ? "config read" : "counter read", longint'(rdata_main), e);
        check(tag, "narrow read", longint'(rdata_narrow), addr ? e : (e % 256));
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run hung, actual 0 expected 1");
            report();
        end
    end

    initial begin
        logic [31:0] held;
        idle(3);
        @(negedge clk); #1;
        rst = 1'b0;
        // R1: reset state, then 1/1 ratio starts from edge after release
        check("R1", "reset us_tick", longint'(tick_main), 0);
        check("R1", "reset rdata", longint'(rdata_main), 0);
        plan(edge_no, 0, 0);
        mon_on = 1'b1;
        do_read(1'b1, "R1");
        idle(20);
        do_read(1'b0, "R7");          // read on a tick cycle: pre-increment value
        idle(280);
        do_read(1'b0, "R6");          // narrow counter has wrapped by now
        held = rdata_main;
        idle(5);
        check("R8", "rdata held", longint'(rdata_main), longint'(held));

        // R3: 19.2 MHz style ratio 5/96
        write_reg(1'b1, 4, 95, "R5");
        idle(3);
        cur_tag = "R3";
        idle(300);
        do_read(1'b0, "R7");
        do_read(1'b1, "R2");
        idle(100);

        // R3: 13 MHz and 26 MHz style ratios
        write_reg(1'b1, 0, 12, "R5");
        idle(2); cur_tag = "R3";
        idle(60);
        do_read(1'b0, "R3");

        // R9: write to counter address is ignored
        write_reg(1'b0, 9, 9, "R9");
        idle(40);
        do_read(1'b1, "R9");

        write_reg(1'b1, 0, 25, "R5");
        idle(2); cur_tag = "R3";
        idle(80);
        do_read(1'b0, "R3");

        // R4: dividend not below divisor
        write_reg(1'b1, 7, 2, "R4");
        idle(20);
        write_reg(1'b1, 200, 3, "R4");
        idle(20);
        do_read(1'b0, "R4");

        // R5: back-to-back writes restart twice
        write_reg(1'b1, 2, 6, "R5");
        write_reg(1'b1, 1, 4, "R5");
        idle(40);
        do_read(1'b0, "R5");
        do_read(1'b1, "R2");

        done = 1'b1;
        report();
    end

endmodule